// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block lets an 8-bit processor core reach an external static RAM over a shared address/data port. The core presents a 16-bit address, a write byte and a read or write request. The controller then sequences the external bus. It first puts the low address byte on the shared port and pulses the address-latch strobe, so that an external transparent latch holds that byte. It then turns the same port around for the data byte. The high address byte has its own output-only port, which is held for the whole access. Active-low read and write strobes qualify the data transfer. A one-cycle done pulse returns to the core, with the read byte for reads.

The shared port is exposed as three plain signals (`ad_out`, `ad_oe`, `ad_in`), so the pad cell that merges them into one bidirectional pin sits in the pad ring. The core's `cfg_en` turns the interface on. `cfg_wait` inserts one extra strobe cycle into each access that starts while it is set.

States, in order: `ST_IDLE`, `ST_ALE` (latch strobe high, low address driven), `ST_AHOLD` (latch strobe low, address still driven), `ST_SETUP` (write data driven, or port released for a read, with strobes inactive), `ST_STROBE` (read or write strobe low), `ST_XWAIT` (second strobe cycle, only when wait was sampled set), `ST_TAIL` (strobe released, write data still driven, done high). The transitions are: IDLE→ALE on an accepted request; ALE→AHOLD→SETUP→STROBE unconditionally; STROBE→XWAIT when the sampled wait bit is set, otherwise STROBE→TAIL; XWAIT→TAIL; TAIL→IDLE. From any state, a low `cfg_en` sends the sequencer to IDLE.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`=0, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0 and `rsp_done`=0.
- R2: A request is accepted only at a clock edge where the controller is idle, `cfg_en`=1 and `req_rd` or `req_wr` is 1. If both are 1, the access is a write. A request raised while `busy`=1 (including the done cycle) or while `cfg_en`=0 produces no latch strobe.
- R3: In the first cycle after acceptance, `ale`=1, `ad_oe`=1, `ad_out` equals address bits 7:0 and `addr_hi` equals address bits 15:8. `addr_hi` keeps that value until the next accepted access.
- R4: In the second cycle, `ale` is 0 while `ad_oe`=1 and `ad_out` still carries the low address byte, so the latch strobe falls before the address leaves the port.
- R5: In the third cycle, both strobes are high. For a write, `ad_oe`=1 and `ad_out` carries the write byte. For a read, `ad_oe`=0.
- R6: For a write, `wr_n` is low for one contiguous strobe period. `ad_oe`=1 and `ad_out` equal the write byte throughout that period and in the cycle after `wr_n` rises.
- R7: For a read, `ad_oe`=0 for as long as `rd_n` is low. `rsp_rdata` takes the value on `ad_in` in the last cycle with `rd_n` low, and it holds that value from the done cycle until the next read completes.
- R8: `rsp_done` is 1 for exactly one cycle: the fifth cycle after the accepting edge, or the sixth with the wait cycle. `busy` is 1 from the first to the last of those cycles and 0 after them.
- R9: `cfg_wait` is sampled at the accepting edge. With it sampled 1, the strobe is low for 2 cycles; with it sampled 0, for 1 cycle. A change of `cfg_wait` during the access has no effect.
- R10: With `cfg_en`=0, the controller stays idle: strobes high, `ale`=0, `ad_oe`=0. If `cfg_en` falls during an access, the next cycle is idle with all strobes inactive, the port released and no done pulse.
- R11: `rd_n` and `wr_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Interface enable |
| cfg_wait | input | 1 | Add one strobe cycle to the next access |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Last read byte |
| rsp_done | output | 1 | One-cycle access completion |
| busy | output | 1 | Access in progress |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A new request and the completion of the current access can meet in the same cycle. The controller must not start a second access while it is still signalling done. The bench provokes this by raising a fresh write request in the exact cycle where `rsp_done` is high, releasing it one edge later. It then counts latch strobes over the following cycles and expects none, with `busy` back to 0. A related overlap is a request raised during the address phase of a running access. That request must also leave exactly one latch strobe and an unchanged latched address.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ALE    = 3'd1,
        ST_AHOLD  = 3'd2,
        ST_SETUP  = 3'd3,
        ST_STROBE = 3'd4,
        ST_XWAIT  = 3'd5,
        ST_TAIL   = 3'd6
    } xm_state_e;

endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_en,
    input  logic      req_rd,
    input  logic      req_wr,
    input  logic      wt_q,
    output xm_state_e state,
    output logic      accept,
    output logic      last_strobe
);

    xm_state_e nxt;

    always_comb begin
        accept      = (state == ST_IDLE) && cfg_en && (req_rd || req_wr);
        last_strobe = ((state == ST_STROBE) && !wt_q) || (state == ST_XWAIT);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = accept ? ST_ALE : ST_IDLE;
            ST_ALE:    nxt = ST_AHOLD;
            ST_AHOLD:  nxt = ST_SETUP;
            ST_SETUP:  nxt = ST_STROBE;
            ST_STROBE: nxt = wt_q ? ST_XWAIT : ST_TAIL;
            ST_XWAIT:  nxt = ST_TAIL;
            ST_TAIL:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!cfg_en) begin
            nxt = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // R2
    ale_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALE) |-> ($past(state) == ST_IDLE));

    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (state == ST_IDLE));

endmodule

// File: rtl/xmem_req.sv
module xmem_req
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              last_strobe,
    input  logic              cfg_en,
    input  logic              cfg_wait,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    input  xm_state_e         state,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              is_wr_q,
    output logic              wt_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            is_wr_q <= 1'b0;
            wt_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            is_wr_q <= req_wr;
            wt_q    <= cfg_wait;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (last_strobe && !is_wr_q && cfg_en) begin
            rdata_q <= ad_in;
        end
    end

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(wt_q));

endmodule

// File: rtl/xmem_drv.sv
module xmem_drv
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xm_state_e         state,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              is_wr_q,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              done,
    output logic              busy
);

    localparam int HI_W = ADDR_W - DATA_W;

    always_comb begin
        addr_hi = addr_q[ADDR_W-1 -: HI_W];
        ale     = 1'b0;
        ad_oe   = 1'b0;
        ad_out  = addr_q[DATA_W-1:0];
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        done    = 1'b0;
        busy    = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: begin
            end
            ST_ALE: begin
                ale   = 1'b1;
                ad_oe = 1'b1;
            end
            ST_AHOLD: begin
                ad_oe = 1'b1;
            end
            ST_SETUP: begin
                ad_oe  = is_wr_q;
                ad_out = wdata_q;
            end
            ST_STROBE, ST_XWAIT: begin
                ad_oe  = is_wr_q;
                ad_out = wdata_q;
                wr_n   = !is_wr_q;
                rd_n   = is_wr_q;
            end
            ST_TAIL: begin
                ad_oe  = is_wr_q;
                ad_out = wdata_q;
                done   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));

    // R4
    ale_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ale) && busy) |-> (ad_oe && (ad_out == $past(ad_out))));

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R6
    wr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_n) && busy) |-> (ad_oe && $stable(ad_out)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wait,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              busy,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);

    xm_state_e         state;
    logic              accept;
    logic              last_strobe;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              is_wr_q;
    logic              wt_q;

    xmem_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_en      (cfg_en),
        .req_rd      (req_rd),
        .req_wr      (req_wr),
        .wt_q        (wt_q),
        .state       (state),
        .accept      (accept),
        .last_strobe (last_strobe)
    );

    xmem_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .last_strobe (last_strobe),
        .cfg_en      (cfg_en),
        .cfg_wait    (cfg_wait),
        .req_wr      (req_wr),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .ad_in       (ad_in),
        .state       (state),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .is_wr_q     (is_wr_q),
        .wt_q        (wt_q),
        .rdata_q     (rsp_rdata)
    );

    xmem_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .is_wr_q (is_wr_q),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .addr_hi (addr_hi),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .done    (rsp_done),
        .busy    (busy)
    );

endmodule

// File: tb/tb_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module tb_xmem_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_en, cfg_wait, req_rd, req_wr;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic [7:0]  rsp_rdata, ad_out, ad_in, addr_hi;
    logic        rsp_done, busy, ad_oe, ale, rd_n, wr_n;

    int checks = 0;
    int fails  = 0;

    // bench memory model state
    logic [7:0] lat_lo = 8'h00;
    bit  prev_ale = 0;
    int  ale_cnt, wr_cyc, rd_cyc;
    logic [7:0] wr_data;
    bit  hold_bad, wr_oe_bad, rd_oe_bad, both_bad;

    always #2 clk = ~clk;

    xmem_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wait(cfg_wait),
        .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .busy(busy), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    assign ad_in = !rd_n ? mem_byte({addr_hi, lat_lo}) : 8'hEE;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                ale_cnt++;
                lat_lo = ad_out;
            end
            if (prev_ale && !ale && busy && !(ad_oe && ad_out == lat_lo)) hold_bad = 1;
            if (!wr_n) begin
                wr_cyc++;
                wr_data = ad_out;
                if (!ad_oe) wr_oe_bad = 1;
            end
            if (!rd_n) begin
                rd_cyc++;
                if (ad_oe) rd_oe_bad = 1;
            end
            if (!rd_n && !wr_n) both_bad = 1;
            prev_ale = ale;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        ale_cnt = 0; wr_cyc = 0; rd_cyc = 0;
        hold_bad = 0; wr_oe_bad = 0; rd_oe_bad = 0; both_bad = 0;
    endtask

    task automatic do_access(input bit wr, input bit rd, input logic [15:0] a,
                             input logic [7:0] d, input bit wt,
                             input bit poke_busy, input bit poke_done);
        int n;
        int exp_lat;
        bit is_w;
        is_w    = wr;
        exp_lat = wt ? 6 : 5;
        @(negedge clk);
        clr_mon();
        req_wr = wr; req_rd = rd; req_addr = a; req_wdata = d; cfg_wait = wt;
        @(negedge clk);
        req_wr = 0; req_rd = 0; cfg_wait = !wt;
        n = 1;
        chk(ale && ad_oe && ad_out == a[7:0], "R3 addr phase", int'(ad_out), int'(a[7:0]));
        chk(addr_hi == a[15:8], "R3 high byte", int'(addr_hi), int'(a[15:8]));
        if (poke_busy) begin
            req_rd = 1; req_addr = ~a;
        end
        while (!rsp_done && n < 12) begin
            @(negedge clk);
            n++;
            if (n == 2) begin
                req_rd = 0; req_addr = a;
            end
            if (n == 3) begin
                if (is_w) chk(ad_oe && wr_n && rd_n && ad_out == d, "R5 write setup", int'(ad_out), int'(d));
                else      chk(!ad_oe && rd_n && wr_n, "R5 read setup", int'(ad_oe), 0);
            end
        end
        chk(n == exp_lat, "R8 latency", n, exp_lat);
        chk(ale_cnt == 1 && lat_lo == a[7:0], "R2 single latch", ale_cnt, 1);
        chk(addr_hi == a[15:8], "R3 high byte held", int'(addr_hi), int'(a[15:8]));
        chk(!hold_bad, "R4 latch hold", int'(hold_bad), 0);
        chk(!both_bad, "R11 strobe exclusion", int'(both_bad), 0);
        if (is_w) begin
            chk(wr_cyc == (wt ? 2 : 1) && rd_cyc == 0, "R9 write strobe width", wr_cyc, wt ? 2 : 1);
            chk(wr_data == d && !wr_oe_bad, "R6 write data", int'(wr_data), int'(d));
            chk(ad_oe && ad_out == d && wr_n, "R6 data after strobe", int'(ad_out), int'(d));
        end else begin
            chk(rd_cyc == (wt ? 2 : 1) && wr_cyc == 0, "R9 read strobe width", rd_cyc, wt ? 2 : 1);
            chk(rsp_rdata == mem_byte(a), "R7 read data", int'(rsp_rdata), int'(mem_byte(a)));
            chk(!rd_oe_bad, "R7 port released", int'(rd_oe_bad), 0);
        end
        if (poke_done) begin
            req_wr = 1; req_addr = 16'h1234;
        end
        @(negedge clk);
        req_wr = 0; req_addr = a;
        chk(!rsp_done && !busy, "R8 done one cycle", int'(rsp_done), 0);
        if (!is_w) chk(rsp_rdata == mem_byte(a), "R7 read data held", int'(rsp_rdata), int'(mem_byte(a)));
        if (poke_done) begin
            repeat (3) @(negedge clk);
            chk(ale_cnt == 1 && !busy, "R2 done-cycle request ignored", ale_cnt, 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd20240611));
        rst_n = 0; cfg_en = 1; cfg_wait = 0; req_rd = 0; req_wr = 0;
        req_addr = 16'h0000; req_wdata = 8'h00;
        clr_mon();
        repeat (3) @(negedge clk);
        chk(!busy && !ale && rd_n && wr_n && !ad_oe && !rsp_done, "R1 in reset", int'(busy), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !ale && rd_n && wr_n && !ad_oe && !rsp_done, "R1 after reset", int'(busy), 0);

        // directed corners
        do_access(1, 0, 16'hA55A, 8'hC3, 0, 0, 0);
        do_access(0, 1, 16'hA55A, 8'h00, 0, 0, 0);
        do_access(1, 0, 16'hFF00, 8'h00, 1, 0, 0);
        do_access(0, 1, 16'h00FF, 8'h00, 1, 0, 0);
        do_access(1, 1, 16'h1357, 8'h9E, 0, 0, 0);   // R2 write wins
        do_access(0, 1, 16'h2468, 8'h00, 0, 1, 0);   // R2 request while busy
        do_access(1, 0, 16'hBEEF, 8'h7F, 1, 0, 1);   // R2 request in done cycle
        do_access(0, 1, 16'h8001, 8'h00, 1, 0, 1);

        // R10 disabled: requests ignored
        @(negedge clk);
        clr_mon();
        held = rsp_rdata;
        cfg_en = 0; req_rd = 1; req_addr = 16'h4444;
        repeat (4) begin
            @(negedge clk);
            chk(!busy && !ale && rd_n && wr_n && !ad_oe, "R10 disabled idle", int'(busy), 0);
        end
        req_rd = 0;
        chk(ale_cnt == 0 && rsp_rdata == held, "R2 disabled no access", ale_cnt, 0);
        cfg_en = 1;

        // R10 abort mid-strobe
        @(negedge clk);
        clr_mon();
        req_rd = 1; req_addr = 16'h5A5A; cfg_wait = 1;
        @(negedge clk);
        req_rd = 0;
        repeat (3) @(negedge clk);
        chk(!rd_n, "R10 strobe before abort", int'(rd_n), 0);
        cfg_en = 0;
        @(negedge clk);
        chk(!busy && rd_n && wr_n && !ad_oe && !ale && !rsp_done, "R10 abort", int'(busy), 0);
        cfg_en = 1;
        repeat (3) begin
            @(negedge clk);
            chk(!rsp_done && !busy, "R10 no done after abort", int'(rsp_done), 0);
        end

        // constrained random
        for (int i = 0; i < 40; i++) begin
            bit w;
            w = $urandom_range(0, 1);
            do_access(w, !w, 16'($urandom), 8'($urandom), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule